// File: doc/BRIEF.md
# Six-Phase Space-Vector Switching Sequencer

This block drives the six leg signals of a two-level inverter feeding a machine with two isolated three-phase windings. Every switching period it plays a centre-aligned, mirror-symmetric run of 6-bit switching states. The states are picked from a per-sector table for the twelve angular sectors. A control loop upstream supplies the sector, the modulation mode and the per-slot dwell counts. This block only turns those numbers into leg timing.

Two modes are offered. The conventional mode uses the all-off null state at both ends of the period and four active states. The reduced common-mode mode replaces the null with a pair of active states that together average to zero. In that mode each three-phase half always has one or two legs high, so its neutral swing stays at a third of the conventional worst case.

All inputs are captured only at the period boundary, so a period always completes with the settings it began with.

Top module: `svm6_sequencer`

## Requirements
- R1: While reset is asserted, `legs_o`, `cm_abc_o`, `cm_xyz_o`, `strobe_o` and `sat_o` are all zero.
- R2: A switching-state index n drives the legs as bit 5 = Sa, bit 4 = Sb, bit 3 = Sc, bit 2 = Sx, bit 1 = Sy, bit 0 = Sz of `legs_o`.
- R3: Conventional mode (`rcm_i`=0): sector k (1..12) uses the four consecutive entries starting at position k-1 of the cyclic list 45, 37, 36, 52, 54, 22, 18, 26, 27, 11, 9, 41. The period runs 0, a1, a2, a3, a4, a3, a2, a1, 0, with a4 played once at the centre.
- R4: Reduced mode (`rcm_i`=1): the period runs z1, a1, a2, a3, a4, z2, a4, a3, a2, a1, z1. The (z1, z2) pair is (49, 14) for sectors 12 and 1, (21, 42) for 2 and 3, (28, 35) for 4 and 5, (14, 49) for 6 and 7, (42, 21) for 8 and 9, and (35, 28) for 10 and 11.
- R5: Dwell slot 0 is the start state, slots 1..4 are a1..a4, and slot 5 is the reduced-mode centre (ignored in conventional mode). Each slot other than the centre one gets floor(d/2) cycles on the way in and d - floor(d/2) cycles on the way out. Every cycle left over in the period is added to the final start-state interval.
- R6: A period lasts `period_i` cycles, and a value of 0 counts as 1. Sector, mode, period and dwells are captured only at the boundary and hold for the whole period. `strobe_o` is high only in the first cycle of each period.
- R7: A captured sector value outside 1..12 is ignored, and the previous valid sector stays in use.
- R8: When the effective dwell sum exceeds the period, the a4 dwell is reduced to fit, or to zero if the other slots alone fill the period, and `sat_o` is high for that period. Otherwise `sat_o` is low.
- R9: `cm_abc_o` and `cm_xyz_o` give the number of high legs in Sa..Sc and Sx..Sz respectively. The codes 0 and 3 mean the full half-bus level, and 1 and 2 mean the one-sixth level.
- R10: In reduced mode no half ever shows 000 or 111, so both codes stay in 1..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_i | input | 4 | Sector number 1..12 |
| rcm_i | input | 1 | 1 selects reduced common-mode sequence |
| period_i | input | W | Period length in clock cycles |
| dwell_i | input | 6*W | Dwell counts, slot j at bits [j*W +: W] |
| legs_o | output | 6 | Leg states Sa..Sz (bit 5..bit 0) |
| cm_abc_o | output | 2 | High-leg count of first half |
| cm_xyz_o | output | 2 | High-leg count of second half |
| strobe_o | output | 1 | First cycle of a new period |
| sat_o | output | 1 | Dwell sum was clipped this period |

## Verification
The hardest case to reach is an input change that lands partway through a period, because it must not disturb the period that is running. The bench handles this by loading the next test's sector, mode, period and dwells in the first cycle of each checked period, then comparing every remaining cycle against the old settings. Odd dwells, a zero-length period, clipping with both partial and total loss of the a4 slot, and out-of-range sectors are all put into this same period-by-period stream over all twelve sectors in both modes.

// File: rtl/svm6_pkg.sv
package svm6_pkg;

  typedef logic [5:0] svec_t;

  localparam int unsigned SECTORS = 12;
  localparam int unsigned SLOTS   = 6;
  localparam int unsigned ACTS    = 4;
  localparam int unsigned SEGS    = 11;

  // Cyclic list of active states; sector k starts at position k-1
  function automatic svec_t ring_vec(input logic [3:0] idx);
    case (idx)
      4'd0:    ring_vec = 6'd45;
      4'd1:    ring_vec = 6'd37;
      4'd2:    ring_vec = 6'd36;
      4'd3:    ring_vec = 6'd52;
      4'd4:    ring_vec = 6'd54;
      4'd5:    ring_vec = 6'd22;
      4'd6:    ring_vec = 6'd18;
      4'd7:    ring_vec = 6'd26;
      4'd8:    ring_vec = 6'd27;
      4'd9:    ring_vec = 6'd11;
      4'd10:   ring_vec = 6'd9;
      4'd11:   ring_vec = 6'd41;
      default: ring_vec = 6'd45;
    endcase
  endfunction

  // First state of the virtual-zero pair per sector group
  function automatic svec_t vz_first(input logic [2:0] grp);
    case (grp)
      3'd0:    vz_first = 6'd49;
      3'd1:    vz_first = 6'd21;
      3'd2:    vz_first = 6'd28;
      3'd3:    vz_first = 6'd14;
      3'd4:    vz_first = 6'd42;
      3'd5:    vz_first = 6'd35;
      default: vz_first = 6'd49;
    endcase
  endfunction

  // Second state is the first state of the group three steps away
  function automatic svec_t vz_second(input logic [2:0] grp);
    if (grp < 3'd3) vz_second = vz_first(grp + 3'd3);
    else            vz_second = vz_first(grp - 3'd3);
  endfunction

endpackage

// File: rtl/svm6_vector_lut.sv
module svm6_vector_lut
  import svm6_pkg::*;
(
  input  logic [3:0]          sector_i,
  input  logic                rcm_i,
  output logic [SLOTS*6-1:0]  slots_o
);

  logic [3:0] base;
  logic [2:0] grp;
  svec_t      act [ACTS];

  assign base = sector_i - 4'd1;
  assign grp  = (sector_i == 4'd12) ? 3'd0 : sector_i[3:1];

  genvar j;
  generate
    for (j = 0; j < int'(ACTS); j++) begin : g_act
      logic [3:0] pos_raw;
      logic [3:0] pos;
      assign pos_raw = base + 4'(j);
      assign pos     = (pos_raw >= 4'(SECTORS)) ? pos_raw - 4'(SECTORS) : pos_raw;
      assign act[j]  = ring_vec(pos);
      assign slots_o[(j+1)*6 +: 6] = act[j];
    end
  endgenerate

  assign slots_o[0 +: 6]        = rcm_i ? vz_first(grp)  : 6'd0;
  assign slots_o[(SLOTS-1)*6 +: 6] = rcm_i ? vz_second(grp) : act[ACTS-1];

endmodule

// File: rtl/svm6_cm_level.sv
module svm6_cm_level (
  input  logic [2:0] half_i,
  output logic [1:0] code_o
);

  assign code_o = {1'b0, half_i[0]} + {1'b0, half_i[1]} + {1'b0, half_i[2]};

endmodule

// File: rtl/svm6_dwell_timer.sv
module svm6_dwell_timer
  import svm6_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rcm_i,
  input  logic [W-1:0]       period_i,
  input  logic [SLOTS*W-1:0] dwell_i,
  output logic               load_o,
  output logic               run_o,
  output logic               rcm_o,
  output logic [3:0]         seg_o,
  output logic               strobe_o,
  output logic               sat_o
);

  localparam int unsigned SW = W + 3;

  logic           run_q, rcm_q, sat_q;
  logic [W-1:0]   cnt_q, last_q;
  logic [W-1:0]   dur_q [SLOTS];

  logic           load;
  logic [W-1:0]   cnt_n, p_eff, d4_n;
  logic           sat_n;
  logic [SW-1:0]  others, full;

  logic [SW-1:0]  len [SEGS-1];
  logic [3:0]     seg;

  // ---------------- next state ----------------
  assign load  = !run_q || (cnt_q == last_q);
  assign cnt_n = load ? '0 : cnt_q + 1'b1;
  assign p_eff = (period_i == '0) ? W'(1) : period_i;

  always_comb begin
    others = SW'(dwell_i[0 +: W]) + SW'(dwell_i[W +: W]) + SW'(dwell_i[2*W +: W])
           + SW'(dwell_i[3*W +: W]) + (rcm_i ? SW'(dwell_i[5*W +: W]) : '0);
    full   = others + SW'(dwell_i[4*W +: W]);
    sat_n  = 1'b0;
    d4_n   = dwell_i[4*W +: W];
    if (full > SW'(p_eff)) begin
      sat_n = 1'b1;
      if (others >= SW'(p_eff)) d4_n = '0;
      else                      d4_n = W'(SW'(p_eff) - others);
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rcm_q  <= 1'b0;
      sat_q  <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
      for (int k = 0; k < int'(SLOTS); k++) dur_q[k] <= '0;
    end else begin
      run_q <= 1'b1;
      cnt_q <= cnt_n;
      if (load) begin
        rcm_q  <= rcm_i;
        sat_q  <= sat_n;
        last_q <= p_eff - 1'b1;
        for (int k = 0; k < int'(SLOTS); k++) begin
          if (k == 4) dur_q[k] <= d4_n;
          else        dur_q[k] <= dwell_i[k*W +: W];
        end
      end
    end
  end

  // ---------------- segment lengths and position ----------------
  always_comb begin
    len[0] = SW'(dur_q[0] >> 1);
    len[1] = SW'(dur_q[1] >> 1);
    len[2] = SW'(dur_q[2] >> 1);
    len[3] = SW'(dur_q[3] >> 1);
    len[4] = rcm_q ? SW'(dur_q[4] >> 1) : '0;
    len[5] = rcm_q ? SW'(dur_q[5]) : SW'(dur_q[4]);
    len[6] = rcm_q ? SW'(dur_q[4] - (dur_q[4] >> 1)) : '0;
    len[7] = SW'(dur_q[3] - (dur_q[3] >> 1));
    len[8] = SW'(dur_q[2] - (dur_q[2] >> 1));
    len[9] = SW'(dur_q[1] - (dur_q[1] >> 1));
  end

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    seg = '0;
    for (int k = 0; k < int'(SEGS) - 1; k++) begin
      acc = acc + len[k];
      if (SW'(cnt_q) >= acc) seg = seg + 4'd1;
    end
  end

  assign load_o   = load;
  assign run_o    = run_q;
  assign rcm_o    = rcm_q;
  assign seg_o    = seg;
  assign strobe_o = run_q && (cnt_q == '0);
  assign sat_o    = sat_q;

  // ---------------- assertions ----------------
  logic [SW-1:0] total_q;
  assign total_q = SW'(dur_q[0]) + SW'(dur_q[1]) + SW'(dur_q[2]) + SW'(dur_q[3])
                 + SW'(dur_q[4]) + (rcm_q ? SW'(dur_q[5]) : '0);

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= last_q));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (cnt_q == last_q)) |=> (cnt_q == '0));

  assert_fit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sat_q) |-> (total_q <= SW'(last_q) + 1'b1));

  assert_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && sat_q) |-> ((total_q == SW'(last_q) + 1'b1) || (dur_q[4] == '0)));

endmodule

// File: rtl/svm6_sequencer.sv
module svm6_sequencer
  import svm6_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         sector_i,
  input  logic               rcm_i,
  input  logic [W-1:0]       period_i,
  input  logic [SLOTS*W-1:0] dwell_i,
  output logic [5:0]         legs_o,
  output logic [1:0]         cm_abc_o,
  output logic [1:0]         cm_xyz_o,
  output logic               strobe_o,
  output logic               sat_o
);

  logic              load, run, rcm_q;
  logic [3:0]        seg;
  logic [3:0]        sector_q;
  logic [3:0]        sector_n;
  logic              sector_ok;
  logic [SLOTS*6-1:0] slots;
  logic [3:0]        slot;
  logic [1:0]        cm [2];

  svm6_dwell_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rcm_i    (rcm_i),
    .period_i (period_i),
    .dwell_i  (dwell_i),
    .load_o   (load),
    .run_o    (run),
    .rcm_o    (rcm_q),
    .seg_o    (seg),
    .strobe_o (strobe_o),
    .sat_o    (sat_o)
  );

  // sector capture: only valid values replace the held sector
  assign sector_ok = (sector_i >= 4'd1) && (sector_i <= 4'(SECTORS));
  assign sector_n  = (load && sector_ok) ? sector_i : sector_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sector_q <= 4'd1;
    else        sector_q <= sector_n;
  end

  svm6_vector_lut u_lut (
    .sector_i (sector_q),
    .rcm_i    (rcm_q),
    .slots_o  (slots)
  );

  // mirror the segment index onto the slot list
  assign slot   = (seg <= 4'(SLOTS-1)) ? seg : 4'(SEGS-1) - seg;
  assign legs_o = run ? slots[slot*6 +: 6] : 6'd0;

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      svm6_cm_level u_cm (
        .half_i (legs_o[h*3 +: 3]),
        .code_o (cm[h])
      );
    end
  endgenerate

  assign cm_abc_o = cm[1];
  assign cm_xyz_o = cm[0];

  // ---------------- assertions ----------------
  assert_inner_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rcm_q) |-> ((cm_abc_o == 2'd1 || cm_abc_o == 2'd2) &&
                        (cm_xyz_o == 2'd1 || cm_xyz_o == 2'd2)));

  assert_conv_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rcm_q && seg == 4'd0) |-> (legs_o == 6'd0));

  assert_sector_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_q >= 4'd1) && (sector_q <= 4'(SECTORS)));

endmodule

// File: tb/test_svm6_sequencer.sv
module test_svm6_sequencer;

  localparam int W  = 12;
  localparam int NT = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [3:0]     sector_i;
  logic           rcm_i;
  logic [W-1:0]   period_i;
  logic [6*W-1:0] dwell_i;
  logic [5:0]     legs_o;
  logic [1:0]     cm_abc_o, cm_xyz_o;
  logic           strobe_o, sat_o;

  always #4 clk = ~clk;

  svm6_sequencer #(.W(W)) i_svm6_sequencer (
    .clk(clk), .rst_n(rst_n), .sector_i(sector_i), .rcm_i(rcm_i),
    .period_i(period_i), .dwell_i(dwell_i), .legs_o(legs_o),
    .cm_abc_o(cm_abc_o), .cm_xyz_o(cm_xyz_o), .strobe_o(strobe_o), .sat_o(sat_o)
  );

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  int ring [12] = '{45, 37, 36, 52, 54, 22, 18, 26, 27, 11, 9, 41};
  int vza  [6]  = '{49, 21, 28, 14, 42, 35};
  int vzb  [6]  = '{14, 42, 35, 49, 21, 28};

  int p_sec [NT];
  int p_md  [NT];
  int p_per [NT];
  int p_d   [NT][6];

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int popc3(input int v);
    return (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1);
  endfunction

  function automatic int peff(input int i);
    return (p_per[i] == 0) ? 1 : p_per[i];
  endfunction

  function automatic int others(input int i);
    return p_d[i][0] + p_d[i][1] + p_d[i][2] + p_d[i][3] + (p_md[i] != 0 ? p_d[i][5] : 0);
  endfunction

  function automatic int exp_sat(input int i);
    return (others(i) + p_d[i][4] > peff(i)) ? 1 : 0;
  endfunction

  function automatic int exp_d4(input int i);
    if (exp_sat(i) == 0) return p_d[i][4];
    if (others(i) >= peff(i)) return 0;
    return peff(i) - others(i);
  endfunction

  // expected state at cycle c of period i in effective sector s
  function automatic int exp_vec(input int i, input int s, input int c);
    int a [4];
    int v [11];
    int l [10];
    int d [6];
    int pos;
    int g;
    for (int j = 0; j < 4; j++) a[j] = ring[(s - 1 + j) % 12];
    for (int k = 0; k < 6; k++) d[k] = p_d[i][k];
    d[4] = exp_d4(i);
    g = (s % 12) / 2;
    if (p_md[i] != 0) begin
      v = '{vza[g], a[0], a[1], a[2], a[3], vzb[g], a[3], a[2], a[1], a[0], vza[g]};
      l = '{d[0]/2, d[1]/2, d[2]/2, d[3]/2, d[4]/2, d[5],
            d[4]-d[4]/2, d[3]-d[3]/2, d[2]-d[2]/2, d[1]-d[1]/2};
    end else begin
      v = '{0, a[0], a[1], a[2], a[3], a[3], a[3], a[2], a[1], a[0], 0};
      l = '{d[0]/2, d[1]/2, d[2]/2, d[3]/2, 0, d[4],
            0, d[3]-d[3]/2, d[2]-d[2]/2, d[1]-d[1]/2};
    end
    pos = 0;
    for (int k = 0; k < 10; k++) begin
      if (c < pos + l[k]) return v[k];
      pos += l[k];
    end
    return v[10];
  endfunction

  task automatic apply(input int i);
    sector_i = 4'(p_sec[i]);
    rcm_i    = (p_md[i] != 0);
    period_i = W'(p_per[i]);
    for (int k = 0; k < 6; k++) dwell_i[k*W +: W] = W'(p_d[i][k]);
  endtask

  task automatic set_p(input int i, input int s, input int m, input int p,
                       input int d0, input int d1, input int d2,
                       input int d3, input int d4, input int d5);
    p_sec[i] = s; p_md[i] = m; p_per[i] = p;
    p_d[i][0] = d0; p_d[i][1] = d1; p_d[i][2] = d2;
    p_d[i][3] = d3; p_d[i][4] = d4; p_d[i][5] = d5;
  endtask

  initial begin
    int eff;
    string rq;
    // sweep: all sectors, both modes, odd and even dwells (R3 R4 R5)
    for (int i = 0; i < 24; i++)
      set_p(i, (i % 12) + 1, i / 12, 40, 4 + (i % 3), 3 + (i % 4), 2 + (i % 5),
            5, 6 + (i % 2), 3 + (i % 3));
    set_p(24, 3, 1, 20, 4, 4, 4, 4, 8, 3);   // R8 partial clip of a4
    set_p(25, 7, 0, 16, 6, 6, 6, 6, 5, 0);   // R8 a4 removed, truncated
    set_p(26, 11, 1, 30, 5, 5, 5, 5, 5, 5);  // exact fit, no saturation
    set_p(27, 0, 1, 30, 5, 3, 4, 5, 6, 1);   // R7 sector 0 ignored
    set_p(28, 13, 0, 24, 3, 3, 3, 3, 3, 0);  // R7 sector 13 ignored
    set_p(29, 12, 1, 3, 0, 0, 0, 0, 0, 0);   // short period, start state only
    set_p(30, 2, 0, 0, 0, 0, 0, 0, 0, 0);    // R6 zero period counts as one
    set_p(31, 6, 1, 25, 2, 7, 1, 3, 5, 4);

    rst_n = 1'b0;
    apply(0);
    repeat (3) @(negedge clk);
    check("R1 legs", int'(legs_o), 0);
    check("R1 cm_abc", int'(cm_abc_o), 0);
    check("R1 cm_xyz", int'(cm_xyz_o), 0);
    check("R1 strobe", int'(strobe_o), 0);
    check("R1 sat", int'(sat_o), 0);
    rst_n = 1'b1;

    eff = 1;
    for (int i = 0; i < NT; i++) begin
      if (p_sec[i] >= 1 && p_sec[i] <= 12) eff = p_sec[i];
      if (i == 27 || i == 28)  rq = "R7";
      else if (p_md[i] != 0)   rq = "R4 R5 R2";
      else                     rq = "R3 R5 R2";
      @(negedge clk);
      while (strobe_o !== 1'b1) @(negedge clk);
      for (int c = 0; c < peff(i); c++) begin
        if (c > 0) @(negedge clk);
        check(rq, int'(legs_o), exp_vec(i, eff, c));
        check("R9 abc", int'(cm_abc_o), popc3(exp_vec(i, eff, c) >> 3));
        check("R9 xyz", int'(cm_xyz_o), popc3(exp_vec(i, eff, c) & 7));
        check("R6 strobe", int'(strobe_o), (c == 0) ? 1 : 0);
        if (p_md[i] != 0) begin
          check("R10 abc", int'(cm_abc_o == 2'd1 || cm_abc_o == 2'd2), 1);
          check("R10 xyz", int'(cm_xyz_o == 2'd1 || cm_xyz_o == 2'd2), 1);
        end
        if (c == 0) begin
          check("R8 sat", int'(sat_o), exp_sat(i));
          // R6: next settings arrive mid-period and must wait for the boundary
          if (i + 1 < NT) apply(i + 1);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule